// File: doc/BRIEF.md
# Sliding Window Jet Finder

This block searches one calorimeter snapshot per bunch crossing for jets. The snapshot is a 16×16 grid of towers indexed by eta and phi. Every tower carries two 16-bit values: an electromagnetic layer value and a hadronic layer value. The inner 8×8 towers form the core, where jets may be centred. The outer ring of 4 towers on each side is environment only. It feeds the window sums and the neighbour comparisons, but no jet is ever reported there.

A `start` pulse captures the whole grid and the configuration in one cycle. The block then works through three passes:

- Phase-axis strip sums for every grid cell.
- Full square window sums, one per grid cell.
- A scan of the 64 core positions in eta-major order.

At each core position the block tests whether it is a local maximum and whether it passes the energy threshold. Each accepted position leaves as one record on a valid/ready stream. While `roi_valid` is high and `roi_ready` is low, the record is held unchanged and the scan waits. `done` pulses once after the last record has been taken.

Top module: `jet_finder`

## Requirements
- R1: While reset is asserted, and on leaving it, `roi_valid` and `done` are 0.
- R2: A tower's energy is the unsigned sum of its electromagnetic and hadronic words, held in 17 bits so that two 16'hFFFF inputs give 131070.
- R3: The energy of a position is the sum of tower energies over the square of half-width h centred on it, covering (2h+1)×(2h+1) towers. Towers in the environment ring count, towers outside the grid count as zero, and the 24-bit sum does not overflow even with all 81 towers at maximum.
- R4: The half-width h is taken from `cfg_half` at `start`, with 0 treated as 1 and values above 4 treated as 4. The neighbourhood radius is taken from `cfg_nbr`, with 0 treated as 1 and values above 2 treated as 2.
- R5: A core position is a local maximum only under two conditions. Its energy must be strictly greater than that of every neighbour earlier in eta-major order, which means lower eta, or equal eta and lower phi. It must also be greater than or equal to that of every later neighbour. Neighbours are the positions within the radius on both axes, including environment positions.
- R6: A local maximum is reported only if its energy is greater than or equal to `cfg_thr` as captured at `start`.
- R7: Records come out in increasing order of eta×8+phi. `roi_eta` and `roi_phi` are core indices 0..7, equal to the grid index minus 4.
- R8: While `roi_valid` is high and `roi_ready` is low, `roi_valid` stays high and `roi_eta`, `roi_phi` and `roi_energy` stay stable.
- R9: `done` is high for exactly one cycle, after the last record's handshake, or after the scan if no record was accepted. `roi_valid` is low while `done` is high.
- R10: The grid and configuration are captured only by a `start` that arrives while idle. Changes to the grid inputs, or a `start` during processing, do not affect the records produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture grid and configuration, begin processing (ignored while busy) |
| cfg_half | input | 3 | Window half-width, valid range 1..4 |
| cfg_nbr | input | 2 | Local-maximum neighbourhood radius, valid range 1..2 |
| cfg_thr | input | 24 | Minimum reported energy |
| em_grid | input | 4096 | Electromagnetic words; tower (eta,phi) at bits [(eta*16+phi)*16 +: 16] |
| had_grid | input | 4096 | Hadronic words, same layout |
| roi_valid | output | 1 | Record available |
| roi_ready | input | 1 | Consumer accepts the record |
| roi_eta | output | 3 | Core eta index of the record |
| roi_phi | output | 3 | Core phi index of the record |
| roi_energy | output | 24 | Window energy of the record |
| done | output | 1 | One-cycle pulse when the grid is finished |

## Verification
Each input pattern is compared against a bench model that recomputes the window sums, the peak rule and the threshold.

- **Isolated single tower.** Creates a plateau of equal sums, so only the tie-break can pick the first position of that plateau.
- **Two equal adjacent towers.** Separates the strict rule applied to earlier neighbours from the non-strict rule applied to later ones.
- **Saturated full grid.** Probes sum width and shows that the environment lowers the sums of edge windows.
- **Large tower in the environment.** Shows it suppressing a weaker core peak.
- **Threshold exactly at the energy, and one above.** Locates the threshold boundary.
- **Sparse pseudo-random grids.** Swept over all half-widths, both radii and out-of-range settings, with a randomly stalled consumer. These exercise ordering, hold-under-stall, clamping, and immunity to a mid-run grid change or repeated `start`.

// File: rtl/jet_finder_pkg.sv
package jet_finder_pkg;
  localparam int DEF_GRID  = 16;
  localparam int DEF_CORE  = 8;
  localparam int DEF_TW    = 16;
  localparam int DEF_HWMAX = 4;
  localparam int DEF_NRMAX = 2;
  localparam int DEF_GROWW = 7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_VSUM,
    S_WSUM,
    S_SCAN,
    S_WAIT,
    S_FIN
  } jf_state_t;
endpackage

// File: rtl/jf_grid_store.sv
module jf_grid_store #(
  parameter int GRID = 16,
  parameter int TW   = 16,
  localparam int EW    = TW + 1,
  localparam int NCELL = GRID * GRID
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NCELL*TW-1:0]   em_flat,
  input  logic [NCELL*TW-1:0]   had_flat,
  output logic [NCELL*EW-1:0]   energy_flat
);
  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    logic [EW-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cell_q <= '0;
      else if (load) cell_q <= EW'(em_flat[c*TW +: TW]) + EW'(had_flat[c*TW +: TW]);
    end
    assign energy_flat[c*EW +: EW] = cell_q;
  end
endmodule

// File: rtl/jf_line_sum.sv
module jf_line_sum #(
  parameter int GRID      = 16,
  parameter int IW        = 17,
  parameter int OW        = 24,
  parameter int HWMAX     = 4,
  parameter int HALFW     = 3,
  parameter int ALONG_ETA = 0,
  localparam int IDXW = $clog2(GRID)
) (
  input  logic [GRID*GRID*IW-1:0] vals,
  input  logic [IDXW-1:0]         eta,
  input  logic [IDXW-1:0]         phi,
  input  logic [HALFW-1:0]        half,
  output logic [OW-1:0]           sum
);
  always_comb begin
    int e, p, ad;
    e = 0;
    p = 0;
    ad = 0;
    sum = '0;
    for (int d = -HWMAX; d <= HWMAX; d++) begin
      ad = (d < 0) ? -d : d;
      e = int'(eta) + ((ALONG_ETA != 0) ? d : 0);
      p = int'(phi) + ((ALONG_ETA != 0) ? 0 : d);
      if (ad <= int'(half) && e >= 0 && e < GRID && p >= 0 && p < GRID)
        sum = sum + OW'(vals[(e*GRID+p)*IW +: IW]);
    end
  end
endmodule

// File: rtl/jf_peak_test.sv
module jf_peak_test #(
  parameter int GRID  = 16,
  parameter int SW    = 24,
  parameter int NRMAX = 2,
  parameter int NRW   = 2,
  localparam int IDXW = $clog2(GRID)
) (
  input  logic [GRID*GRID*SW-1:0] sums,
  input  logic [IDXW-1:0]         eta,
  input  logic [IDXW-1:0]         phi,
  input  logic [NRW-1:0]          radius,
  output logic                    is_peak
);
  logic [SW-1:0] centre;
  assign centre = sums[(int'(eta)*GRID + int'(phi))*SW +: SW];

  always_comb begin
    int e, p;
    logic [SW-1:0] nb;
    e = 0;
    p = 0;
    nb = '0;
    is_peak = 1'b1;
    for (int de = -NRMAX; de <= NRMAX; de++) begin
      for (int dp = -NRMAX; dp <= NRMAX; dp++) begin
        e = int'(eta) + de;
        p = int'(phi) + dp;
        if ((de != 0 || dp != 0) &&
            ((de < 0) ? -de : de) <= int'(radius) &&
            ((dp < 0) ? -dp : dp) <= int'(radius) &&
            e >= 0 && e < GRID && p >= 0 && p < GRID) begin
          nb = sums[(e*GRID+p)*SW +: SW];
          if (de < 0 || (de == 0 && dp < 0)) begin
            if (!(centre > nb)) is_peak = 1'b0;
          end else begin
            if (!(centre >= nb)) is_peak = 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/jet_finder.sv
module jet_finder
  import jet_finder_pkg::*;
#(
  parameter int GRID  = DEF_GRID,
  parameter int CORE  = DEF_CORE,
  parameter int TW    = DEF_TW,
  parameter int HWMAX = DEF_HWMAX,
  parameter int NRMAX = DEF_NRMAX,
  parameter int GROWW = DEF_GROWW,
  localparam int ENV   = (GRID - CORE) / 2,
  localparam int EW    = TW + 1,
  localparam int SUMW  = EW + GROWW,
  localparam int IDXW  = $clog2(GRID),
  localparam int CIDXW = $clog2(CORE),
  localparam int NCELL = GRID * GRID,
  localparam int CNTW  = 2 * IDXW,
  localparam int KW    = 2 * CIDXW,
  localparam int HALFW = $clog2(HWMAX + 1),
  localparam int NRW   = $clog2(NRMAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [HALFW-1:0]     cfg_half,
  input  logic [NRW-1:0]       cfg_nbr,
  input  logic [SUMW-1:0]      cfg_thr,
  input  logic [NCELL*TW-1:0]  em_grid,
  input  logic [NCELL*TW-1:0]  had_grid,
  output logic                 roi_valid,
  input  logic                 roi_ready,
  output logic [CIDXW-1:0]     roi_eta,
  output logic [CIDXW-1:0]     roi_phi,
  output logic [SUMW-1:0]      roi_energy,
  output logic                 done
);
  jf_state_t state;
  logic [CNTW-1:0]  idx;
  logic [KW-1:0]    k;
  logic [HALFW-1:0] half_q;
  logic [NRW-1:0]   nr_q;
  logic [SUMW-1:0]  thr_q;

  logic [NCELL*EW-1:0]   energy_flat;
  logic [SUMW-1:0]       vsum_mem [NCELL];
  logic [SUMW-1:0]       wsum_mem [NCELL];
  logic [NCELL*SUMW-1:0] vsum_flat;
  logic [NCELL*SUMW-1:0] wsum_flat;
  logic [SUMW-1:0]       vs_out, ws_out;

  logic            load;
  logic [IDXW-1:0] cell_eta, cell_phi, sc_eta, sc_phi;
  logic [SUMW-1:0] cur_sum;
  logic            is_peak, accept;

  assign load     = start && (state == S_IDLE);
  assign cell_eta = idx[CNTW-1:IDXW];
  assign cell_phi = idx[IDXW-1:0];
  assign sc_eta   = IDXW'(k[KW-1:CIDXW]) + IDXW'(ENV);
  assign sc_phi   = IDXW'(k[CIDXW-1:0]) + IDXW'(ENV);
  assign cur_sum  = wsum_mem[{sc_eta, sc_phi}];
  assign accept   = is_peak && (cur_sum >= thr_q);
  assign done     = (state == S_FIN);

  jf_grid_store #(.GRID(GRID), .TW(TW)) u_store (
    .clk(clk), .rst_n(rst_n), .load(load),
    .em_flat(em_grid), .had_flat(had_grid), .energy_flat(energy_flat)
  );

  jf_line_sum #(.GRID(GRID), .IW(EW), .OW(SUMW), .HWMAX(HWMAX),
                .HALFW(HALFW), .ALONG_ETA(0)) u_strip (
    .vals(energy_flat), .eta(cell_eta), .phi(cell_phi), .half(half_q), .sum(vs_out)
  );

  jf_line_sum #(.GRID(GRID), .IW(SUMW), .OW(SUMW), .HWMAX(HWMAX),
                .HALFW(HALFW), .ALONG_ETA(1)) u_square (
    .vals(vsum_flat), .eta(cell_eta), .phi(cell_phi), .half(half_q), .sum(ws_out)
  );

  jf_peak_test #(.GRID(GRID), .SW(SUMW), .NRMAX(NRMAX), .NRW(NRW)) u_peak (
    .sums(wsum_flat), .eta(sc_eta), .phi(sc_phi), .radius(nr_q), .is_peak(is_peak)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_flat
    assign vsum_flat[c*SUMW +: SUMW] = vsum_mem[c];
    assign wsum_flat[c*SUMW +: SUMW] = wsum_mem[c];
  end

  always_ff @(posedge clk) begin
    if (state == S_VSUM) vsum_mem[idx] <= vs_out;
    if (state == S_WSUM) wsum_mem[idx] <= ws_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx        <= '0;
      k          <= '0;
      half_q     <= HALFW'(1);
      nr_q       <= NRW'(1);
      thr_q      <= '0;
      roi_valid  <= 1'b0;
      roi_eta    <= '0;
      roi_phi    <= '0;
      roi_energy <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          half_q <= (cfg_half == '0) ? HALFW'(1) :
                    (int'(cfg_half) > HWMAX) ? HALFW'(HWMAX) : cfg_half;
          nr_q   <= (cfg_nbr == '0) ? NRW'(1) :
                    (int'(cfg_nbr) > NRMAX) ? NRW'(NRMAX) : cfg_nbr;
          thr_q  <= cfg_thr;
          idx    <= '0;
          state  <= S_VSUM;
        end
        S_VSUM: begin
          idx <= idx + 1'b1;
          if (idx == '1) state <= S_WSUM;
        end
        S_WSUM: begin
          idx <= idx + 1'b1;
          if (idx == '1) begin
            k     <= '0;
            state <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (accept) begin
            roi_valid  <= 1'b1;
            roi_eta    <= k[KW-1:CIDXW];
            roi_phi    <= k[CIDXW-1:0];
            roi_energy <= cur_sum;
            state      <= S_WAIT;
          end else if (k == '1) begin
            state <= S_FIN;
          end else begin
            k <= k + 1'b1;
          end
        end
        S_WAIT: if (roi_ready) begin
          roi_valid <= 1'b0;
          if (k == '1) state <= S_FIN;
          else begin
            k     <= k + 1'b1;
            state <= S_SCAN;
          end
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/jet_finder_chk.sv
module jet_finder_chk #(
  parameter int SUMW  = 24,
  parameter int CIDXW = 3,
  parameter int HALFW = 3,
  parameter int HWMAX = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             roi_valid,
  input logic             roi_ready,
  input logic [CIDXW-1:0] roi_eta,
  input logic [CIDXW-1:0] roi_phi,
  input logic [SUMW-1:0]  roi_energy,
  input logic             done,
  input logic [SUMW-1:0]  thr_q,
  input logic [HALFW-1:0] half_q
);
  logic                 have_last;
  logic [2*CIDXW-1:0]   last_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_pos  <= '0;
    end else if (done) begin
      have_last <= 1'b0;
    end else if (roi_valid && roi_ready) begin
      have_last <= 1'b1;
      last_pos  <= {roi_eta, roi_phi};
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !roi_valid && !done);

  p_half_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q >= HALFW'(1)) && (int'(half_q) <= HWMAX));

  p_over_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    roi_valid |-> roi_energy >= thr_q);

  p_scan_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(roi_valid) && have_last |-> {roi_eta, roi_phi} > last_pos);

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    roi_valid && !roi_ready |=> roi_valid && $stable(roi_eta) &&
                                $stable(roi_phi) && $stable(roi_energy));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !roi_valid);
endmodule

bind jet_finder jet_finder_chk #(.SUMW(SUMW), .CIDXW(CIDXW), .HALFW(HALFW), .HWMAX(HWMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .roi_valid(roi_valid), .roi_ready(roi_ready),
  .roi_eta(roi_eta), .roi_phi(roi_phi), .roi_energy(roi_energy),
  .done(done), .thr_q(thr_q), .half_q(half_q)
);

// File: tb/jet_finder_tb.sv
module jet_finder_tb;
  localparam int GRID  = 16;
  localparam int TW    = 16;
  localparam int SUMW  = 24;
  localparam int NCELL = GRID * GRID;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic start = 1'b0;
  logic [2:0] cfg_half = 3'd1;
  logic [1:0] cfg_nbr = 2'd1;
  logic [SUMW-1:0] cfg_thr = '0;
  logic [NCELL*TW-1:0] em_grid = '0;
  logic [NCELL*TW-1:0] had_grid = '0;
  logic roi_valid, roi_ready, done;
  logic [2:0] roi_eta, roi_phi;
  logic [SUMW-1:0] roi_energy;

  always #4 clk = ~clk;

  jet_finder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_half(cfg_half), .cfg_nbr(cfg_nbr),
    .cfg_thr(cfg_thr), .em_grid(em_grid), .had_grid(had_grid),
    .roi_valid(roi_valid), .roi_ready(roi_ready), .roi_eta(roi_eta),
    .roi_phi(roi_phi), .roi_energy(roi_energy), .done(done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int em_a [GRID][GRID];
  int had_a[GRID][GRID];
  int exp_eta[64], exp_phi[64], exp_en[64];
  int n_exp;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 16);
  endfunction

  function automatic int twr(int e, int p);
    if (e < 0 || e >= GRID || p < 0 || p >= GRID) return 0;
    return em_a[e][p] + had_a[e][p];
  endfunction

  function automatic int wsum(int e, int p, int h);
    int s = 0;
    for (int de = -h; de <= h; de++)
      for (int dp = -h; dp <= h; dp++)
        s += twr(e + de, p + dp);
    return s;
  endfunction

  task automatic clear_grid();
    for (int e = 0; e < GRID; e++)
      for (int p = 0; p < GRID; p++) begin
        em_a[e][p] = 0;
        had_a[e][p] = 0;
      end
  endtask

  task automatic fill_rand(int one_in, int maxv);
    for (int e = 0; e < GRID; e++)
      for (int p = 0; p < GRID; p++) begin
        em_a[e][p]  = (rnd() % one_in == 0) ? rnd() % maxv : 0;
        had_a[e][p] = (rnd() % one_in == 0) ? rnd() % maxv : 0;
      end
  endtask

  task automatic build_expected(int half, int nr, int thr);
    int h, r, c, n;
    bit pk;
    h = (half < 1) ? 1 : (half > 4) ? 4 : half;
    r = (nr < 1) ? 1 : (nr > 2) ? 2 : nr;
    n_exp = 0;
    for (int ke = 0; ke < 8; ke++)
      for (int kp = 0; kp < 8; kp++) begin
        c = wsum(ke + 4, kp + 4, h);
        pk = 1'b1;
        for (int de = -r; de <= r; de++)
          for (int dp = -r; dp <= r; dp++)
            if (de != 0 || dp != 0) begin
              n = wsum(ke + 4 + de, kp + 4 + dp, h);
              if (de < 0 || (de == 0 && dp < 0)) begin
                if (!(c > n)) pk = 1'b0;
              end else if (!(c >= n)) pk = 1'b0;
            end
        if (pk && c >= thr) begin
          exp_eta[n_exp] = ke;
          exp_phi[n_exp] = kp;
          exp_en[n_exp]  = c;
          n_exp++;
        end
      end
  endtask

  task automatic run(string req, int half, int nr, int thr, bit stall, bit disturb);
    int got = 0;
    int cyc = 0;
    bit pend = 1'b0;
    bit seen_done = 1'b0;
    logic [2:0] s_eta, s_phi;
    logic [SUMW-1:0] s_en;
    s_eta = '0;
    s_phi = '0;
    s_en = '0;
    for (int e = 0; e < GRID; e++)
      for (int p = 0; p < GRID; p++) begin
        em_grid[(e*GRID+p)*TW +: TW]  = TW'(em_a[e][p]);
        had_grid[(e*GRID+p)*TW +: TW] = TW'(had_a[e][p]);
      end
    cfg_half = 3'(half);
    cfg_nbr  = 2'(nr);
    cfg_thr  = SUMW'(thr);
    build_expected(half, nr, thr);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (cyc < 20000 && !seen_done) begin
      @(negedge clk);
      cyc++;
      // R10: disturb the grid inputs and retrigger start mid-run
      if (disturb && cyc == 40) begin
        em_grid = ~em_grid;
        cfg_thr = '0;
        start = 1'b1;
      end else start = 1'b0;
      if (pend)
        chk(roi_valid && roi_eta == s_eta && roi_phi == s_phi && roi_energy == s_en,
            "R8", "held record under stall", int'(roi_energy), int'(s_en));
      roi_ready = stall ? ((rnd() % 3) != 0) : 1'b1;
      if (roi_valid && roi_ready) begin
        if (got < n_exp) begin
          chk(int'(roi_eta) == exp_eta[got], req, "R7 eta index", int'(roi_eta), exp_eta[got]);
          chk(int'(roi_phi) == exp_phi[got], req, "R7 phi index", int'(roi_phi), exp_phi[got]);
          chk(int'(roi_energy) == exp_en[got], req, "R3 energy", int'(roi_energy), exp_en[got]);
        end
        got++;
      end
      pend = roi_valid && !roi_ready;
      if (pend) begin
        s_eta = roi_eta;
        s_phi = roi_phi;
        s_en  = roi_energy;
      end
      if (done) begin
        seen_done = 1'b1;
        chk(!roi_valid, "R9", "valid low during done", int'(roi_valid), 0);
      end
    end
    chk(seen_done, "R9", "done reached (watchdog)", int'(seen_done), 1);
    chk(got == n_exp, req, "R5 record count", got, n_exp);
    @(negedge clk);
    chk(!done, "R9", "done single cycle", int'(done), 0);
    em_grid = '0;
  endtask

  initial begin
    roi_ready = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!roi_valid && !done, "R1", "idle in reset", int'(roi_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!roi_valid && !done, "R1", "idle after reset", int'(done), 0);

    // R3/R5: lone tower forms a plateau; tie-break keeps its first position
    clear_grid();
    em_a[6][9] = 100; had_a[6][9] = 50;
    run("R5", 1, 1, 0, 1'b0, 1'b0);
    chk(n_exp == 1 && exp_en[0] == 150, "R2", "model sanity lone tower", exp_en[0], 150);

    // R2: maximum words in both layers
    clear_grid();
    em_a[8][7] = 65535; had_a[8][7] = 65535;
    run("R2", 2, 1, 0, 1'b1, 1'b0);

    // R3: saturated grid with widest window, no overflow
    for (int e = 0; e < GRID; e++)
      for (int p = 0; p < GRID; p++) begin
        em_a[e][p] = 65535;
        had_a[e][p] = 65535;
      end
    run("R3", 4, 2, 0, 1'b0, 1'b0);

    // R5: two equal adjacent towers, earlier wins
    clear_grid();
    em_a[7][7] = 400; em_a[7][8] = 400;
    run("R5", 1, 1, 0, 1'b0, 1'b0);

    // R5: environment tower suppresses weaker core peak
    clear_grid();
    em_a[4][4] = 300; em_a[2][4] = 800;
    run("R5", 1, 2, 0, 1'b0, 1'b0);

    // R6: threshold at and just above the energy
    clear_grid();
    em_a[9][9] = 150;
    run("R6", 1, 1, 150, 1'b0, 1'b0);
    run("R6", 1, 1, 151, 1'b0, 1'b0);

    // R4: out-of-range settings saturate
    fill_rand(6, 4000);
    run("R4", 0, 0, 0, 1'b1, 1'b0);
    run("R4", 7, 3, 0, 1'b1, 1'b0);

    // R7/R8: sweep half-widths and radii with stalls
    for (int h = 1; h <= 4; h++)
      for (int r = 1; r <= 2; r++) begin
        fill_rand(5, 3000);
        run("R7", h, r, 500, 1'b1, 1'b0);
      end

    // R10: mid-run grid change and repeated start
    fill_rand(4, 5000);
    run("R10", 2, 1, 200, 1'b1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule